// File: doc/BRIEF.md
# Counter CSR Access Controller

This block holds the machine cycle counter and the retired-instruction counter for a 32-bit core. It also decides whether each counter CSR access returns data or raises an illegal-instruction trap. The core presents one access at a time with these inputs: the 12-bit CSR address, the operation, whether the source register is x0, and the current privilege. In the same cycle the block returns the read data and a trap flag. Any write is committed at the next rising clock edge.

The time counter is never stored here. Reads of the user time view take the 64-bit timer value from an input port in the same cycle. One build option makes every time access trap, so that machine software emulates the read. A second option keeps only the low 32 bits of each counter in hardware. In that build the high-half addresses trap, and a wrap of the low half raises a one-cycle overflow request, so that software can keep the upper word. A per-counter enable register with hard-wired bits decides which user views a user-mode program may read.

Top module: `ctr_csr_unit`

## Requirements
- R1: In the full build, mcycle (0xB00/0xB80) and minstret (0xB02/0xB82) are 64 bits wide. The low word is at the first address of each pair and the high word at the second. A carry out of bit 31 increments the high word.
- R2: The enable register (0x306) resets to 0. A write stores the data ANDed with the parameter EN_MASK. Bits cleared in the mask read back as zero. Bit 0 is cycle, bit 1 is time, bit 2 is instret.
- R3: A user-mode read of a user counter view traps exactly when its enable bit is 0. The views are cycle 0xC00/0xC80, time 0xC01/0xC81 and instret 0xC02/0xC82. Machine mode reads them freely. The cycle and instret views return the machine counters. Time returns mtime_i[31:0] and timeh returns mtime_i[63:32], both from the same cycle.
- R4: Any write form to a user counter view traps, in either privilege. Set (op 2) or clear (op 3) with the source register x0 is a plain read and does not trap. Operation codes are: 0 read, 1 write, 2 set, 3 clear.
- R5: With TIME_TRAP set, every access to 0xC01 or 0xC81 traps, including a plain read from machine mode.
- R6: Machine counter addresses and 0x306 trap from user mode. From machine mode, write stores the data, set ORs it into the old value, and clear removes its bits from the old value. The read data is always the old value.
- R7: A trapped access changes no state and returns 0. An address outside the decoded set returns 0 without a trap. With no access valid, the read data and the trap flag are 0.
- R8: mcycle increments on every clock and minstret on each cycle with retire_i high. A committed write to either half of a counter replaces that half and suppresses the counter's increment in that cycle.
- R9: With LOW_COST set, the counters are 32 bits wide and the high-half addresses trap. A wrap of a low word sets its ovf_o bit (bit 0 cycle, bit 2 instret) for one cycle, in the cycle the counter reads 0. In the full build ovf_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_valid_i | input | 1 | A CSR access is presented this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | XLEN | Write, set or clear operand |
| csr_rs1_zero_i | input | 1 | Source register is x0 |
| priv_m_i | input | 1 | 1 machine mode, 0 user mode |
| retire_i | input | 1 | One instruction retires this cycle |
| mtime_i | input | 2*XLEN | External timer value |
| csr_rdata_o | output | XLEN | Read data (old value) |
| csr_trap_o | output | 1 | Illegal-instruction trap request |
| ovf_o | output | 3 | Low-word wrap request per counter |
| cnt_en_o | output | 3 | User counter enable register |

## Verification
Two builds are driven from shared stimulus: a full build with all enable bits writable, and a low-cost build with time trapping and the time enable bit hard-wired. The test sweeps all eight enable values across the six user view addresses in user mode. This separates a wrong enable bit, wrong masking and wrong high-half handling. It also sweeps every write form, with and without x0 as source, over the user views, which separates write-form detection from plain reads. Read-modify chains on mcycle, a low-word carry into the high word, retire bursts, and a write that collides with a retire pin down the counting and write priority. Trapped writes followed by readback show that no state moved, and wraps in the low-cost build place the overflow pulse on its exact cycle.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;
  localparam int NCTR  = 3;
  localparam int T_IDX = 1;

  localparam logic [11:0] A_UCTR_LO = 12'hC00;
  localparam logic [11:0] A_UCTR_HI = 12'hC80;
  localparam logic [11:0] A_MCTR_LO = 12'hB00;
  localparam logic [11:0] A_MCTR_HI = 12'hB80;
  localparam logic [11:0] A_CNT_EN  = 12'h306;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic user;
    logic mach;
    logic high;
    logic en;
    logic tim;
  } dec_t;
endpackage

// File: rtl/ctr_decode.sv
`timescale 1ns/1ps
module ctr_decode
  import ctr_pkg::*;
(
  input  logic [11:0]     addr_i,
  output dec_t            dec_o,
  output logic [NCTR-1:0] ctr_oh_o
);
  always_comb begin
    dec_o    = '0;
    ctr_oh_o = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (addr_i == A_UCTR_LO + 12'(i)) begin
        ctr_oh_o[i] = 1'b1;
        dec_o.user  = 1'b1;
      end
      if (addr_i == A_UCTR_HI + 12'(i)) begin
        ctr_oh_o[i] = 1'b1;
        dec_o.user  = 1'b1;
        dec_o.high  = 1'b1;
      end
      // no machine-side copy of time: it lives outside the block
      if (i != T_IDX) begin
        if (addr_i == A_MCTR_LO + 12'(i)) begin
          ctr_oh_o[i] = 1'b1;
          dec_o.mach  = 1'b1;
        end
        if (addr_i == A_MCTR_HI + 12'(i)) begin
          ctr_oh_o[i] = 1'b1;
          dec_o.mach  = 1'b1;
          dec_o.high  = 1'b1;
        end
      end
    end
    dec_o.en  = (addr_i == A_CNT_EN);
    dec_o.tim = dec_o.user & ctr_oh_o[T_IDX];
  end
endmodule

// File: rtl/ctr_access.sv
`timescale 1ns/1ps
module ctr_access
  import ctr_pkg::*;
#(
  parameter bit TIME_TRAP = 1'b0,
  parameter bit LOW_COST  = 1'b0
) (
  input  logic            valid_i,
  input  dec_t            dec_i,
  input  logic [NCTR-1:0] ctr_oh_i,
  input  logic [1:0]      op_i,
  input  logic            rs1_zero_i,
  input  logic            priv_m_i,
  input  logic [NCTR-1:0] cnt_en_i,
  output logic            trap_o,
  output logic            commit_o
);
  csr_op_e op;
  logic    wr_form;
  logic    deny_priv, deny_ro, deny_time, deny_en, deny_hi;

  assign op      = csr_op_e'(op_i);
  // set/clear with x0 as source writes nothing
  assign wr_form = (op == OP_WRITE) |
                   (((op == OP_SET) | (op == OP_CLEAR)) & ~rs1_zero_i);

  assign deny_priv = (dec_i.mach | dec_i.en) & ~priv_m_i;
  assign deny_ro   = dec_i.user & wr_form;
  assign deny_time = TIME_TRAP & dec_i.tim;
  assign deny_en   = dec_i.user & ~priv_m_i & |(ctr_oh_i & ~cnt_en_i);
  assign deny_hi   = LOW_COST & dec_i.high;

  assign trap_o   = valid_i & (deny_priv | deny_ro | deny_time | deny_en | deny_hi);
  assign commit_o = valid_i & ~trap_o & wr_form & (dec_i.mach | dec_i.en);
endmodule

// File: rtl/ctr_counter.sv
`timescale 1ns/1ps
module ctr_counter #(
  parameter int XLEN     = 32,
  parameter bit LOW_COST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [2*XLEN-1:0] value_o,
  output logic              carry_o
);
  logic [XLEN-1:0] lo_q;
  logic [XLEN:0]   lo_sum;
  logic            bump;

  // any write to the counter wins over the increment
  assign bump    = inc_i & ~wr_lo_i & ~wr_hi_i;
  assign lo_sum  = {1'b0, lo_q} + 1'b1;
  assign carry_o = bump & lo_sum[XLEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (wr_lo_i) lo_q <= wdata_i;
    else if (bump)    lo_q <= lo_sum[XLEN-1:0];
  end

  if (LOW_COST) begin : g_half
    assign value_o = {{XLEN{1'b0}}, lo_q};
  end else begin : g_full
    logic [XLEN-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hi_q <= '0;
      else if (wr_hi_i) hi_q <= wdata_i;
      else if (carry_o) hi_q <= hi_q + 1'b1;
    end
    assign value_o = {hi_q, lo_q};
  end
endmodule

// File: rtl/ctr_csr_unit.sv
`timescale 1ns/1ps
module ctr_csr_unit
  import ctr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter bit              TIME_TRAP = 1'b0,
  parameter bit              LOW_COST  = 1'b0,
  parameter logic [NCTR-1:0] EN_MASK   = 3'b111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_valid_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              csr_rs1_zero_i,
  input  logic              priv_m_i,
  input  logic              retire_i,
  input  logic [2*XLEN-1:0] mtime_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_trap_o,
  output logic [NCTR-1:0]   ovf_o,
  output logic [NCTR-1:0]   cnt_en_o
);
  dec_t              dec;
  logic [NCTR-1:0]   ctr_oh;
  logic              trap, commit;
  logic [XLEN-1:0]   raw, wval, cnt_en_q;
  logic [2*XLEN-1:0] cval [NCTR];
  logic [NCTR-1:0]   carry, ovf_q;

  ctr_decode u_dec (
    .addr_i   (csr_addr_i),
    .dec_o    (dec),
    .ctr_oh_o (ctr_oh)
  );

  ctr_access #(
    .TIME_TRAP (TIME_TRAP),
    .LOW_COST  (LOW_COST)
  ) u_acc (
    .valid_i    (csr_valid_i),
    .dec_i      (dec),
    .ctr_oh_i   (ctr_oh),
    .op_i       (csr_op_i),
    .rs1_zero_i (csr_rs1_zero_i),
    .priv_m_i   (priv_m_i),
    .cnt_en_i   (cnt_en_q[NCTR-1:0]),
    .trap_o     (trap),
    .commit_o   (commit)
  );

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    if (i == T_IDX) begin : g_time
      assign cval[i]  = mtime_i;
      assign carry[i] = 1'b0;
    end else begin : g_cnt
      logic inc;
      assign inc = (i == 0) ? 1'b1 : retire_i;
      ctr_counter #(
        .XLEN     (XLEN),
        .LOW_COST (LOW_COST)
      ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (inc),
        .wr_lo_i (commit & ctr_oh[i] & ~dec.high),
        .wr_hi_i (commit & ctr_oh[i] & dec.high),
        .wdata_i (wval),
        .value_o (cval[i]),
        .carry_o (carry[i])
      );
    end
  end

  always_comb begin
    raw = '0;
    if (dec.en) raw = cnt_en_q;
    for (int i = 0; i < NCTR; i++) begin
      if (ctr_oh[i]) raw = dec.high ? cval[i][2*XLEN-1:XLEN] : cval[i][XLEN-1:0];
    end
  end

  always_comb begin
    unique case (csr_op_e'(csr_op_i))
      OP_WRITE: wval = csr_wdata_i;
      OP_SET:   wval = raw | csr_wdata_i;
      OP_CLEAR: wval = raw & ~csr_wdata_i;
      default:  wval = raw;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_en_q <= '0;
    else if (commit & dec.en) cnt_en_q <= wval & XLEN'(EN_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= LOW_COST ? carry : '0;
  end

  assign csr_trap_o  = trap;
  assign csr_rdata_o = (csr_valid_i & ~trap) ? raw : '0;
  assign ovf_o       = ovf_q;
  assign cnt_en_o    = cnt_en_q[NCTR-1:0];
endmodule

// File: rtl/ctr_csr_chk.sv
`timescale 1ns/1ps
module ctr_csr_chk
  import ctr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter bit              TIME_TRAP = 1'b0,
  parameter logic [NCTR-1:0] EN_MASK   = 3'b111
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_valid_i,
  input logic [11:0]       csr_addr_i,
  input logic [1:0]        csr_op_i,
  input logic              priv_m_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_trap_o,
  input logic [NCTR-1:0]   ovf_o,
  input logic [NCTR-1:0]   cnt_en_o,
  input logic              commit_i,
  input logic [XLEN-1:0]   wval_i,
  input logic [2*XLEN-1:0] mcyc_i
);
  logic seen_q;
  logic is_time, wr_cyc_lo, wr_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign is_time   = (csr_addr_i == 12'hC01) | (csr_addr_i == 12'hC81);
  assign wr_cyc_lo = commit_i & (csr_addr_i == A_MCTR_LO);
  assign wr_cyc    = wr_cyc_lo | (commit_i & (csr_addr_i == A_MCTR_HI));

  // R2
  en_warl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_o & ~EN_MASK) == '0);

  // R3
  ucyc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_valid_i && !priv_m_i && csr_addr_i == 12'hC00 && !cnt_en_o[0] |-> csr_trap_o);

  // R3
  uinst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_valid_i && !priv_m_i && csr_addr_i == 12'hC02 && !cnt_en_o[2] |-> csr_trap_o);

  // R4
  time_wr_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_valid_i && is_time && csr_op_i == 2'd1 |-> csr_trap_o);

  // R5
  time_opt_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    TIME_TRAP && csr_valid_i && is_time |-> csr_trap_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |-> !csr_trap_o && csr_rdata_o == '0);

  // R7
  trap_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_trap_o |-> !commit_i && csr_rdata_o == '0);

  // R8
  cyc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(wr_cyc) |-> mcyc_i[XLEN-1:0] == $past(mcyc_i[XLEN-1:0]) + 1'b1);

  // R8
  cyc_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc_lo |=> mcyc_i[XLEN-1:0] == $past(wval_i));

  // R9
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o[0] |-> mcyc_i[XLEN-1:0] == '0);
endmodule

bind ctr_csr_unit ctr_csr_chk #(
  .XLEN      (XLEN),
  .TIME_TRAP (TIME_TRAP),
  .EN_MASK   (EN_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_valid_i (csr_valid_i),
  .csr_addr_i  (csr_addr_i),
  .csr_op_i    (csr_op_i),
  .priv_m_i    (priv_m_i),
  .csr_rdata_o (csr_rdata_o),
  .csr_trap_o  (csr_trap_o),
  .ovf_o       (ovf_o),
  .cnt_en_o    (cnt_en_o),
  .commit_i    (commit),
  .wval_i      (wval),
  .mcyc_i      (cval[0])
);

// File: tb/sim_ctr_csr_unit.sv
`timescale 1ns/1ps
module sim_ctr_csr_unit;
  localparam logic [11:0] MCYC = 12'hB00, MCYCH = 12'hB80, MINS = 12'hB02, MINSH = 12'hB82;
  localparam logic [11:0] UCYC = 12'hC00, UCYCH = 12'hC80, UTIM = 12'hC01, UTIMH = 12'hC81;
  localparam logic [11:0] ENR = 12'h306;

  logic        clk = 1'b0, rst_n = 1'b0, v = 1'b0, rz = 1'b1, pm = 1'b1, ret = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  op = '0;
  logic [31:0] wd = '0;
  logic [63:0] mt = 64'h0123_4567_89AB_CDEF;
  logic [31:0] rd0, rd1;
  logic        tr0, tr1;
  logic [2:0]  ov0, ov1, en0, en1;
  int vectors = 0, miscompares = 0;
  logic [31:0] snap;

  always #4 clk = ~clk;

  ctr_csr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(v), .csr_addr_i(addr), .csr_op_i(op),
    .csr_wdata_i(wd), .csr_rs1_zero_i(rz), .priv_m_i(pm), .retire_i(ret), .mtime_i(mt),
    .csr_rdata_o(rd0), .csr_trap_o(tr0), .ovf_o(ov0), .cnt_en_o(en0));

  ctr_csr_unit #(.TIME_TRAP(1'b1), .LOW_COST(1'b1), .EN_MASK(3'b101)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(v), .csr_addr_i(addr), .csr_op_i(op),
    .csr_wdata_i(wd), .csr_rs1_zero_i(rz), .priv_m_i(pm), .retire_i(ret), .mtime_i(mt),
    .csr_rdata_o(rd1), .csr_trap_o(tr1), .ovf_o(ov1), .cnt_en_o(en1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input logic [1:0] o, input logic [31:0] d,
                     input logic z, input logic m);
    @(negedge clk);
    v = 1'b1; addr = a; op = o; wd = d; rz = z; pm = m;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    v = 1'b0;
    #1;
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset en u0", en0, 0);
    chk("R2 reset en u1", en1, 0);
    chk("R9 reset ovf", {ov0, ov1}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    chk("R7 idle trap", {tr0, tr1}, 0);
    chk("R7 idle data", {rd0, rd1}, 0);

    // R1 R8: carry into the high word
    acc(MCYCH, 2'd1, 32'd1, 1'b0, 1'b1);
    chk("R9 high half trap u1", tr1, 1);
    acc(MCYC, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b1);
    acc(MCYC, 2'd0, 0, 1'b1, 1'b1);
    chk("R1 mcycle lo", rd0, 32'hFFFF_FFFF);
    acc(MCYCH, 2'd0, 0, 1'b1, 1'b1);
    chk("R1 mcycleh carry", rd0, 2);
    chk("R9 ovf cycle u1", ov1[0], 1);
    acc(UCYC, 2'd0, 0, 1'b1, 1'b1);
    chk("R3 cycle shadow", rd0, 1);
    acc(UCYCH, 2'd0, 0, 1'b1, 1'b1);
    chk("R3 cycleh shadow", rd0, 2);

    // R6: write/set/clear chain; read data is the old value
    acc(MCYC, 2'd1, 32'h100, 1'b0, 1'b1);
    acc(MCYC, 2'd2, 32'h0F, 1'b0, 1'b1);
    chk("R6 set old", rd0, 32'h100);
    acc(MCYC, 2'd3, 32'h100, 1'b0, 1'b1);
    chk("R6 clear old", rd0, 32'h10F);
    acc(MCYC, 2'd0, 0, 1'b1, 1'b1);
    chk("R6 clear result", rd0, 32'h0F);
    acc(MCYC, 2'd2, 32'hFFFF, 1'b1, 1'b1);
    chk("R4 set x0 no trap", tr0, 0);
    chk("R4 set x0 data", rd0, 32'h10);
    acc(MCYC, 2'd0, 0, 1'b1, 1'b1);
    chk("R8 set x0 wrote nothing", rd0, 32'h11);

    // R8: retire counting and write priority
    acc(MINSH, 2'd1, 0, 1'b0, 1'b1);
    acc(MINS, 2'd1, 0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      idle();
      ret = 1'b1;
    end
    @(negedge clk); ret = 1'b0;
    acc(MINS, 2'd0, 0, 1'b1, 1'b1);
    chk("R8 retire count", rd0, 5);
    acc(MINS, 2'd1, 32'd100, 1'b0, 1'b1);
    ret = 1'b1;
    acc(12'hC02, 2'd0, 0, 1'b1, 1'b1);
    ret = 1'b0;
    chk("R8 write beats retire", rd0, 100);
    acc(12'hC82, 2'd0, 0, 1'b1, 1'b1);
    chk("R3 instreth shadow", rd0, 0);

    // R2 R3 R5 R9: enable sweep, user-mode reads of all six views
    for (int e = 0; e < 8; e++) begin
      acc(ENR, 2'd1, 32'hFFFF_FFF8 | e, 1'b0, 1'b1);
      acc(ENR, 2'd0, 0, 1'b1, 1'b1);
      chk("R2 en readback u0", rd0, e);
      chk("R2 en readback u1", rd1, e & 5);
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < 3; i++) begin
          mt = {16'hA5A5, 16'(e), 16'h5A5A, 16'(i)};
          acc((h != 0 ? UCYCH : UCYC) + 12'(i), 2'd0, 0, 1'b1, 1'b0);
          chk("R3 user gate u0", tr0, ((e >> i) & 1) == 0);
          chk("R3 R5 R9 user gate u1", tr1, (((e & 5) >> i) & 1) == 0 || i == 1 || h != 0);
          if (i == 1 && ((e >> 1) & 1) == 1)
            chk("R3 time view", rd0, h != 0 ? mt[63:32] : mt[31:0]);
        end
      end
    end

    // R4: write forms on user views from M-mode
    for (int a = 0; a < 6; a++) begin
      for (int o = 1; o < 4; o++) begin
        for (int z = 0; z < 2; z++) begin
          acc((a >= 3 ? UCYCH : UCYC) + 12'(a % 3), 2'(o), 32'h5, z[0], 1'b1);
          chk("R4 write form u0", tr0, o == 1 || z == 0);
        end
      end
    end

    // R5: time from M-mode
    mt = 64'hDEAD_BEEF_1357_9BDF;
    acc(UTIM, 2'd0, 0, 1'b1, 1'b1);
    chk("R5 time M u1 trap", tr1, 1);
    chk("R3 time M u0", {tr0, rd0}, {1'b0, 32'h1357_9BDF});
    acc(UTIMH, 2'd0, 0, 1'b1, 1'b1);
    chk("R3 timeh M u0", rd0, 32'hDEAD_BEEF);

    // R6 R7: trapped accesses leave state alone
    acc(MCYC, 2'd0, 0, 1'b1, 1'b1);
    snap = rd0;
    acc(MCYC, 2'd1, 0, 1'b0, 1'b0);
    chk("R6 machine from U trap", {tr0, rd0}, {1'b1, 32'h0});
    acc(UCYC, 2'd1, 0, 1'b0, 1'b1);
    chk("R4 cycle write trap", tr0, 1);
    acc(MCYC, 2'd0, 0, 1'b1, 1'b1);
    chk("R7 mcycle untouched", rd0, snap + 3);
    acc(ENR, 2'd1, 0, 1'b0, 1'b0);
    chk("R6 en from U trap", tr0, 1);
    idle();
    chk("R7 en untouched", en0, 7);
    acc(12'hB01, 2'd0, 0, 1'b1, 1'b1);
    chk("R7 unknown B01", {tr0, rd0}, 0);
    acc(12'h7C0, 2'd1, 32'h1, 1'b0, 1'b1);
    chk("R7 unknown 7C0", {tr0, rd0}, 0);

    // R9: wrap pulses in the low-cost build
    acc(MCYC, 2'd1, 32'hFFFF_FFFD, 1'b0, 1'b1);
    idle(); idle(); idle();
    chk("R9 no early ovf", ov1[0], 0);
    idle();
    chk("R9 cycle ovf pulse", ov1[0], 1);
    chk("R9 full build no ovf", ov0, 0);
    idle();
    chk("R9 ovf one cycle", ov1[0], 0);
    acc(MINS, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b1);
    idle(); ret = 1'b1;
    @(negedge clk); ret = 1'b0; #1;
    chk("R9 instret ovf pulse", ov1[2], 1);
    idle();
    chk("R9 instret ovf clears", ov1[2], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule